// File: doc/BRIEF.md
# Periodic ALIGN Inserter

This block sits on the transmit side of a serial storage link. It merges ALIGN primitive groups into an outgoing 32-bit dword stream at a programmable spacing. Payload dwords arrive with a valid/ready handshake. One dword leaves on every clock, with a per-byte K-character flag.

The block counts the non-ALIGN dwords it sends. After the configured number, it inserts a group of two or four ALIGN primitives. While a group is on the line, the upstream source is stalled. When the source has nothing to offer, a filler dword goes out instead of payload. Filler dwords count toward the spacing, so ALIGNs keep their rhythm on an idle link.

The spacing comes from an 8-bit rate setting. Between groups, exactly (effective rate − 1) non-ALIGN dwords are sent. A rate that is too small for the chosen group size is raised to the smallest legal value.

Top module: `align_inserter`

## Requirements
- R1: During reset and on the first sample after it, the output is the filler word 0xB5B5957C with K flags 4'b0001 and outIsAlign low. inReady is low while reset is asserted.
- R2: Between two successive ALIGN groups, exactly (effective rate − 1) non-ALIGN dwords are emitted. The same count precedes the first group after reset.
- R3: With rate 0xFF and two-ALIGN groups, exactly 254 non-ALIGN dwords separate consecutive groups.
- R4: Every ALIGN dword is 0x7B4A4ABC with K flags 4'b0001 (K on byte 0 only), and outIsAlign is high for it.
- R5: A group is two ALIGN dwords when fourAlign is low at group start, and four when it is high. A group is sent back to back without interruption.
- R6: inReady is low in every cycle that puts an ALIGN on the output and high in every other cycle out of reset.
- R7: A dword accepted (inValid and inReady high at a clock edge) appears on outData after that edge, unchanged, with K flags 4'b0000. Accepted dwords keep their order.
- R8: In a non-group cycle with inValid low, the filler word 0xB5B5957C with K flags 4'b0001 is sent, and it counts toward the spacing.
- R9: The effective rate is the rate setting, except that it is raised to 5 when fourAlign is high and rate ≤ 4, and to 3 when fourAlign is low and rate ≤ 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one dword per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| rate | input | RATE_W | Spacing setting; the effective rate minus one is the count of non-ALIGN dwords between groups |
| fourAlign | input | 1 | High selects four-ALIGN groups, low selects pairs |
| inData | input | 32 | Payload dword from upstream |
| inValid | input | 1 | Upstream offers inData |
| inReady | output | 1 | Block accepts inData at this edge |
| outData | output | 32 | Transmitted dword |
| outCharK | output | 4 | K-character flag per byte of outData |
| outIsAlign | output | 1 | outData carries an ALIGN primitive |

## Verification
The bench targets the smallest spacings: rate 0 and 1 (clamped), and rate 3 with pairs. An off-by-one in the counter shows up there as gaps one dword too long or too short. It also targets an off-by-one in the clamp, which would yield a gap of 1 or 3.

An idle segment with no valid data catches a counter that advances only on payload: there, ALIGNs would vanish entirely. The default 0xFF setting is run long enough to see several full 254-dword gaps.

Random valid patterns, with data held while stalled, expose two further faults. One is a ready that stays high during a group, which loses or duplicates payload. The other is a group cut short, which shows up as a run of ALIGNs with the wrong length.

// File: rtl/align_ins_pkg.sv
package align_ins_pkg;

  localparam int WORD_W = 32;
  localparam int K_W = WORD_W / 8;

  localparam logic [WORD_W-1:0] ALIGN_WORD = 32'h7B4A_4ABC;
  localparam logic [WORD_W-1:0] FILL_WORD  = 32'hB5B5_957C;
  localparam logic [K_W-1:0]    K_BYTE0    = 4'b0001;
  localparam logic [K_W-1:0]    K_NONE     = 4'b0000;

  // strobes from control to datapath for the coming edge
  typedef struct packed {
    logic sendAlign;   // this cycle emits an ALIGN
    logic takeData;    // this cycle may accept payload
  } ctrl_strobe_t;

endpackage

// File: rtl/align_ins_ctrl.sv
module align_ins_ctrl
  import align_ins_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rate,
  input  logic              fourAlign,
  output ctrl_strobe_t      strobe,
  output logic              inReady
);

  localparam logic [RATE_W-1:0] MIN_FOUR = RATE_W'(5);
  localparam logic [RATE_W-1:0] MIN_TWO  = RATE_W'(3);

  function automatic logic [RATE_W-1:0] clampRate(input logic [RATE_W-1:0] r,
                                                  input logic four);
    if (four && r < MIN_FOUR) return MIN_FOUR;
    if (!four && r < MIN_TWO) return MIN_TWO;
    return r;
  endfunction

  logic [RATE_W-1:0] gapTarget;
  logic [RATE_W-1:0] gapCnt;
  logic [RATE_W-1:0] gapNext;
  logic [1:0]        alignCnt;
  logic [1:0]        alignLast;
  logic              inGroup;
  logic              grpFour;

  assign gapTarget = clampRate(rate, fourAlign) - RATE_W'(1);
  assign gapNext   = gapCnt + RATE_W'(1);
  assign alignLast = grpFour ? 2'd3 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt   <= '0;
      alignCnt <= '0;
      inGroup  <= 1'b0;
      grpFour  <= 1'b0;
    end else if (inGroup) begin
      if (alignCnt == alignLast) begin
        inGroup  <= 1'b0;
        gapCnt   <= '0;
        alignCnt <= '0;
      end else begin
        alignCnt <= alignCnt + 2'd1;
      end
    end else begin
      gapCnt <= gapNext;
      if (gapNext >= gapTarget) begin
        inGroup  <= 1'b1;
        alignCnt <= '0;
        grpFour  <= fourAlign;
      end
    end
  end

  assign inReady          = rstN && !inGroup;
  assign strobe.sendAlign = inGroup;
  assign strobe.takeData  = rstN && !inGroup;

  AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!inGroup && $stable(rate) && $stable(fourAlign)) |-> (gapCnt < gapTarget)); // R2

  AST_GROUP_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (inGroup && alignCnt == alignLast) |=> !inGroup); // R5

  AST_GROUP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inGroup && alignCnt != alignLast) |=> inGroup); // R5

  AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (gapTarget >= (fourAlign ? RATE_W'(4) : RATE_W'(2)))); // R9

endmodule

// File: rtl/align_ins_datapath.sv
module align_ins_datapath
  import align_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic [WORD_W-1:0] outData,
  output logic [K_W-1:0]    outCharK,
  output logic              outIsAlign
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData    <= FILL_WORD;
      outCharK   <= K_BYTE0;
      outIsAlign <= 1'b0;
    end else if (strobe.sendAlign) begin
      outData    <= ALIGN_WORD;
      outCharK   <= K_BYTE0;
      outIsAlign <= 1'b1;
    end else if (strobe.takeData && inValid) begin
      outData    <= inData;
      outCharK   <= K_NONE;
      outIsAlign <= 1'b0;
    end else begin
      outData    <= FILL_WORD;
      outCharK   <= K_BYTE0;
      outIsAlign <= 1'b0;
    end
  end

  AST_ALIGN_CODE: assert property (@(posedge clk) disable iff (!rstN)
    outIsAlign |-> (outData == ALIGN_WORD && outCharK == K_BYTE0)); // R4

  AST_PAYLOAD_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.takeData && inValid) |->
      (outData == $past(inData) && outCharK == K_NONE && !outIsAlign)); // R7

endmodule

// File: rtl/align_inserter.sv
module align_inserter
  import align_ins_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rate,
  input  logic              fourAlign,
  input  logic [31:0]       inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [31:0]       outData,
  output logic [3:0]        outCharK,
  output logic              outIsAlign
);

  ctrl_strobe_t strobe;

  align_ins_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rate      (rate),
    .fourAlign (fourAlign),
    .strobe    (strobe),
    .inReady   (inReady)
  );

  align_ins_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .inValid    (inValid),
    .outData    (outData),
    .outCharK   (outCharK),
    .outIsAlign (outIsAlign)
  );

  AST_STALL_IN_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    outIsAlign |-> $past(!inReady)); // R6

endmodule

// File: tb/align_inserter_tb.sv
module align_inserter_tb;

  localparam logic [31:0] ALIGN_W = 32'h7B4A4ABC;
  localparam logic [31:0] FILL_W  = 32'hB5B5957C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rate = 8'hFF;
  logic        fourAlign = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] outData;
  logic [3:0]  outCharK;
  logic        outIsAlign;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit mGroup;
  int mGap, mAlign, mLen;
  logic [31:0] expData;
  logic [3:0]  expK;
  bit          expAlign;
  // run-length observers
  int runData, runAlign;
  bit seenGroup;

  always #10 clk = ~clk;

  align_inserter u_dut (
    .clk(clk), .rstN(rstN), .rate(rate), .fourAlign(fourAlign),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outCharK(outCharK), .outIsAlign(outIsAlign)
  );

  function automatic int effRate(input int r, input bit four);
    if (four && r <= 4) return 5;
    if (!four && r <= 2) return 3;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check(inReady == 1'b0, "R1", "ready in reset", inReady, 0);
    check(outData == FILL_W && outCharK == 4'b0001 && !outIsAlign, "R1",
          "output in reset", outData, FILL_W);
    mGroup = 0; mGap = 0; mAlign = 0; mLen = 2;
    runData = 0; runAlign = 0; seenGroup = 0;
    rstN = 1'b1;
  endtask

  // one line cycle: drive at negedge, check ready, predict, sample next negedge
  task automatic stepCycle(input int validPct, input string gapReq);
    bit accept;
    int eff;
    if (!(inValid && !inReady)) begin
      inValid = ($urandom % 100) < validPct;
      inData  = $urandom;
    end
    #1;
    check(inReady == !mGroup, "R6", "inReady", inReady, !mGroup);
    eff = effRate(rate, fourAlign);
    accept = inValid && inReady;
    if (mGroup) begin
      expData = ALIGN_W; expK = 4'b0001; expAlign = 1;
      mAlign++;
      if (mAlign == mLen) begin mGroup = 0; mGap = 0; end
    end else begin
      if (accept) begin expData = inData; expK = 4'b0000; end
      else begin expData = FILL_W; expK = 4'b0001; end
      expAlign = 0;
      mGap++;
      if (mGap >= eff - 1) begin mGroup = 1; mAlign = 0; mLen = fourAlign ? 4 : 2; end
    end
    @(posedge clk);
    @(negedge clk);
    if (expAlign)
      check(outData == expData && outCharK == expK && outIsAlign, "R4",
            "align dword", outData, expData);
    else if (expK == 4'b0000)
      check(outData == expData && outCharK == expK && !outIsAlign, "R7",
            "payload dword", outData, expData);
    else
      check(outData == expData && outCharK == expK && !outIsAlign, "R8",
            "filler dword", outData, expData);
    // independent run-length observation
    if (outIsAlign) begin
      if (runData > 0) begin
        check(runData == eff - 1, gapReq, "gap length", runData, eff - 1);
        runData = 0;
      end
      runAlign++;
    end else begin
      if (runAlign > 0) begin
        check(runAlign == (fourAlign ? 4 : 2), "R5", "group length", runAlign,
              fourAlign ? 4 : 2);
        runAlign = 0;
        seenGroup = 1;
      end
      runData++;
    end
  endtask

  task automatic segment(input int r, input bit four, input int validPct,
                         input int cycles, input string gapReq);
    rate = 8'(r);
    fourAlign = four;
    doReset();
    for (int i = 0; i < cycles; i++) stepCycle(validPct, gapReq);
    check(seenGroup, gapReq, "groups observed", seenGroup, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1 plus default spacing R3
    segment(8'hFF, 0, 70, 800, "R3");
    // R2 several legal rates
    segment(8, 1, 100, 200, "R2");
    segment(3, 0, 50, 120, "R2");
    segment(5, 1, 80, 150, "R2");
    // R9 clamping
    segment(1, 1, 90, 150, "R9");
    segment(0, 1, 60, 150, "R9");
    segment(4, 1, 60, 150, "R9");
    segment(0, 0, 90, 120, "R9");
    segment(2, 0, 90, 120, "R9");
    // R8 idle line still spaced
    segment(10, 0, 0, 200, "R8");
    segment(10, 1, 0, 200, "R8");
    // random segments
    for (int s = 0; s < 8; s++)
      segment($urandom % 256, $urandom % 2, $urandom % 101, 600, "R2");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule